// File: doc/BRIEF.md
# TDM Audio Receive Serializer with Sample Formatting

This block receives serial audio in frames of one to eight 32-bit slots. It uses a bit clock and a frame sync, both sampled in the system clock domain. It shifts each slot into a word and cuts out a sample of the chosen width. It then places that sample in a 32-bit output word and presents the word on a valid/ready output together with the index of the slot it came from. The control inputs set the formatting: sample width, bit order, justification within the slot and within the word, the fill policy for unused bits, two packed-stereo modes, duplication of the left channel, and per-slot suppression.

A loopback selector takes the serial input from the paired transmitter instead of the data pin. A second capture mode takes pulse-density data on both edges of the bit clock. There is a single output register. A word that arrives while the previous word is still waiting is dropped, and a sticky error flag is raised.

Top module: `tdm_rx_formatter`

## Requirements
- R1: After reset `out_valid` and `overrun` are 0. With all control inputs at 0 the block takes 32-bit samples, MSB first, right justified, zero filled, stereo, with all slots enabled, in receive mode.
- R2: In receive mode (`cfg_mode`=0) data is sampled on bit-clock rising edges. A frame-sync rising edge seen at a bit-clock rising edge marks bit 0 of slot 0. Each slot is 32 bit clocks, and each word carries its slot index on `out_slot`.
- R3: `cfg_size` selects the sample width: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed, 6=8, 7=8 packed. With `cfg_slot_left`=0 the sample is taken from the last N bit times of the slot. With `cfg_slot_left`=1 it is taken from the first N bit times.
- R4: With `cfg_word_left`=0 the sample sits in bits N-1:0 of the word. With `cfg_word_left`=1 it sits in bits 31:32-N. The remaining bits are filled according to `cfg_ext`: 0 gives zeros, 1 gives ones, 2 copies the sample MSB and 3 copies the sample LSB.
- R5: With `cfg_lsb_first`=1 the first bit received within the sample is its LSB. With 0 it is its MSB.
- R6: Size 5 outputs one word per slot pair, on the odd slot, holding {odd[15:0], even[15:0]}. Size 7 outputs {16'h0, odd[7:0], even[7:0]}. Fill and word justification have no effect in these two modes.
- R7: With `cfg_mono`=1 each odd slot delivers the sample of the preceding even slot.
- R8: `cfg_slots` (0..7) sets the slot count minus one. Bits received after the last slot produce no output until the next frame sync. A slot whose bit in `cfg_slot_dis` is set produces no output.
- R9: With `cfg_loop`=1 the serial input is `sd_loop_i` instead of `sd_i`.
- R10: With `cfg_mode`=2 one bit is captured on every bit-clock edge, rising and falling. Every 32 edges counted from reset produce a raw word on slot 0, with the first captured bit in bit 31.
- R11: With `cfg_mode` at 1 or 3 no output is produced.
- R12: A held word (`out_valid`=1, `out_ready`=0) keeps its data and slot stable. A new word arriving then is discarded and sets `overrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock, sampled by clk |
| fs_i | input | 1 | Frame sync |
| sd_i | input | 1 | Serial data pin |
| sd_loop_i | input | 1 | Paired transmitter output for loopback |
| cfg_mode | input | 2 | 0 receive, 2 dual-edge pulse-density, 1/3 reserved |
| cfg_size | input | 3 | Sample size code |
| cfg_ext | input | 2 | Fill policy |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_slot_left | input | 1 | Justification within the slot |
| cfg_word_left | input | 1 | Justification within the word |
| cfg_mono | input | 1 | Left-channel duplication |
| cfg_loop | input | 1 | Loopback input select |
| cfg_slot_dis | input | 8 | Per-slot suppression |
| cfg_slots | input | 3 | Slots per frame minus one |
| out_ready | input | 1 | Consumer accepts the word |
| out_valid | output | 1 | Word available |
| out_data | output | 32 | Formatted word |
| out_slot | output | 3 | Slot index of the word |
| overrun | output | 1 | Sticky discard flag |

## Verification
A bit counter that is off by one misaligns every later slot. It shows up on the first word as a data value shifted by one position, one slot after the frame sync. A wrong slot counter or a wrong frame-done state shows up as a wrong `out_slot`, or as words that appear after the last slot, within the frame being received. A held even-slot sample that is stale shows up in the packed and mono words on the very next odd slot. A wrong handshake state shows up as a changed held word or a missing `overrun` within one clock of the second arrival.

// File: rtl/tdm_rx_formatter.sv
module tdm_rx_formatter #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             fs_i,
  input  logic             sd_i,
  input  logic             sd_loop_i,
  input  logic [1:0]       cfg_mode,
  input  logic [2:0]       cfg_size,
  input  logic [1:0]       cfg_ext,
  input  logic             cfg_lsb_first,
  input  logic             cfg_slot_left,
  input  logic             cfg_word_left,
  input  logic             cfg_mono,
  input  logic             cfg_loop,
  input  logic [SLOTS-1:0] cfg_slot_dis,
  input  logic [SW-1:0]    cfg_slots,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic [SW-1:0]    out_slot,
  output logic             overrun
);

  logic          sck_d, fs_prev, active;
  logic [4:0]    bit_cnt;
  logic [SW-1:0] slot;
  logic [31:0]   sh, held;

  wire rx_mode  = (cfg_mode == 2'd0);
  wire pdm_mode = (cfg_mode == 2'd2);
  wire rise     = sck_i & ~sck_d;
  wire fall     = ~sck_i & sck_d;
  wire din      = cfg_loop ? sd_loop_i : sd_i;
  wire fs_start = rx_mode & rise & fs_i & ~fs_prev;
  wire shift_en = (rx_mode & rise & (active | fs_start)) | (pdm_mode & (rise | fall));

  wire [4:0]    cur_bit  = fs_start ? 5'd0 : bit_cnt;
  wire [SW-1:0] cur_slot = fs_start ? '0 : slot;
  wire          last_bit = shift_en & (cur_bit == 5'd31);
  wire [31:0]   sh_nxt   = cfg_lsb_first ? {din, sh[31:1]} : {sh[30:0], din};

  logic [5:0] n;
  always_comb
    case (cfg_size)
      3'd0:       n = 6'd32;
      3'd1:       n = 6'd24;
      3'd2:       n = 6'd20;
      3'd3:       n = 6'd18;
      3'd4, 3'd5: n = 6'd16;
      default:    n = 6'd8;
    endcase

  wire [5:0]  gap   = 6'd32 - n;
  wire [31:0] mask  = 32'hFFFF_FFFF >> gap;
  wire [31:0] lmask = mask << gap;
  wire [31:0] samp  = (cfg_slot_left ^ cfg_lsb_first) ? (sh_nxt >> gap) : (sh_nxt & mask);
  wire [31:0] cur_s = (cfg_mono & cur_slot[0]) ? held : samp;
  wire        compact = (cfg_size == 3'd5) | (cfg_size == 3'd7);

  logic fill;
  always_comb
    case (cfg_ext)
      2'd0:    fill = 1'b0;
      2'd1:    fill = 1'b1;
      2'd2:    fill = cur_s[5'(n - 6'd1)];
      default: fill = cur_s[0];
    endcase

  logic [31:0] word;
  always_comb
    if (pdm_mode)              word = sh_nxt;
    else if (cfg_size == 3'd5) word = {cur_s[15:0], held[15:0]};
    else if (cfg_size == 3'd7) word = {16'h0, cur_s[7:0], held[7:0]};
    else if (cfg_word_left)    word = (cur_s << gap) | (fill ? ~lmask : 32'h0);
    else                       word = cur_s | (fill ? ~mask : 32'h0);

  wire emit = last_bit &
              (pdm_mode | (~cfg_slot_dis[cur_slot] & ~(compact & ~cur_slot[0])));
  wire [SW-1:0] emit_slot = pdm_mode ? '0 : cur_slot;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_d <= 1'b0;  fs_prev <= 1'b0;  active <= 1'b0;
      bit_cnt <= '0;  slot <= '0;  sh <= '0;  held <= '0;
    end else begin
      sck_d <= sck_i;
      if (rx_mode & rise) fs_prev <= fs_i;
      if (shift_en) begin
        sh <= sh_nxt;
        if (last_bit) begin
          bit_cnt <= '0;
          if (rx_mode & ~cur_slot[0]) held <= samp;
          if (rx_mode) begin
            if (cur_slot == cfg_slots) active <= 1'b0;
            else begin
              active <= 1'b1;
              slot   <= SW'(cur_slot + 1'b1);
            end
          end
        end else begin
          bit_cnt <= cur_bit + 5'd1;
          if (rx_mode) begin
            active <= 1'b1;
            slot   <= cur_slot;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;  out_data <= '0;  out_slot <= '0;  overrun <= 1'b0;
    end else if (emit) begin
      if (out_valid & ~out_ready) overrun <= 1'b1;
      else begin
        out_valid <= 1'b1;
        out_data  <= word;
        out_slot  <= emit_slot;
      end
    end else if (out_ready) out_valid <= 1'b0;

endmodule

// File: rtl/tdm_rx_formatter_chk.sv
module tdm_rx_formatter_chk #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic [2:0]       cfg_size,
  input logic [SLOTS-1:0] cfg_slot_dis,
  input logic [SW-1:0]    cfg_slots,
  input logic             out_ready,
  input logic             out_valid,
  input logic [31:0]      out_data,
  input logic [SW-1:0]    out_slot,
  input logic             overrun
);

  logic [1:0]       mode_q;
  logic [2:0]       size_q;
  logic [SLOTS-1:0] dis_q;
  logic [SW-1:0]    slots_q;

  always_ff @(posedge clk) begin
    mode_q  <= cfg_mode;
    size_q  <= cfg_size;
    dis_q   <= cfg_slot_dis;
    slots_q <= cfg_slots;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_slot)); // R12

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R12

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode[0] && !out_valid |=> !out_valid); // R11

  AST_DISABLED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && mode_q == 2'd0 |-> !dis_q[out_slot]); // R8

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && mode_q == 2'd0 |-> out_slot <= slots_q); // R8

  AST_PACKED_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && mode_q == 2'd0 && (size_q == 3'd5 || size_q == 3'd7)
      |-> out_slot[0]); // R6

  AST_PDM_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && mode_q == 2'd2 |-> out_slot == '0); // R10

endmodule

bind tdm_rx_formatter tdm_rx_formatter_chk #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
  .cfg_slot_dis(cfg_slot_dis), .cfg_slots(cfg_slots), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot), .overrun(overrun)
);

// File: tb/tdm_rx_formatter_test.sv
module tdm_rx_formatter_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, fs = 1'b0, sd = 1'b0, sd_loop = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [2:0] cfg_size = 3'd0;
  logic [1:0] cfg_ext = 2'd0;
  logic cfg_lsb_first = 1'b0, cfg_slot_left = 1'b0, cfg_word_left = 1'b0;
  logic cfg_mono = 1'b0, cfg_loop = 1'b0;
  logic [7:0] cfg_slot_dis = 8'h00;
  logic [2:0] cfg_slots = 3'd0;
  logic out_ready = 1'b1;
  logic out_valid, overrun;
  logic [31:0] out_data;
  logic [2:0] out_slot;

  always #10 clk = ~clk;

  tdm_rx_formatter uut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .fs_i(fs), .sd_i(sd), .sd_loop_i(sd_loop),
    .cfg_mode(cfg_mode), .cfg_size(cfg_size), .cfg_ext(cfg_ext),
    .cfg_lsb_first(cfg_lsb_first), .cfg_slot_left(cfg_slot_left),
    .cfg_word_left(cfg_word_left), .cfg_mono(cfg_mono), .cfg_loop(cfg_loop),
    .cfg_slot_dis(cfg_slot_dis), .cfg_slots(cfg_slots), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_slot(out_slot), .overrun(overrun)
  );

  int nchk = 0, nfail = 0;
  logic sd_inv = 1'b0, loop_inv = 1'b1;
  logic [31:0] frame_w [8];
  logic [31:0] cap_d [16];
  logic [2:0]  cap_s [16];
  int cap_n = 0;

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && cap_n < 16) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_slot;
      cap_n++;
    end

  // {size, ext, lsb_first, slot_left, word_left, stream (first bit = bit 31), expected}
  localparam logic [71:0] VEC [14] = '{
    {3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'hA5C30F96, 32'hA5C30F96},
    {3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 32'h12348765, 32'h00008765},
    {3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 32'h12348765, 32'h00001234},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 32'hFFF12345, 32'h00012345},
    {3'd6, 2'd0, 1'b0, 1'b1, 1'b0, 32'h5A000000, 32'h0000005A},
    {3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h00800001, 32'hFF800001},
    {3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h00123456, 32'hFF123456},
    {3'd6, 2'd3, 1'b0, 1'b0, 1'b0, 32'h00000081, 32'hFFFFFF81},
    {3'd6, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000007F, 32'h0000007F},
    {3'd3, 2'd2, 1'b0, 1'b0, 1'b0, 32'h00020000, 32'hFFFE0000},
    {3'd4, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000ABCD, 32'hABCD0000},
    {3'd4, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000ABCD, 32'hABCDFFFF},
    {3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h8000000F, 32'hF0000001},
    {3'd6, 2'd0, 1'b1, 1'b0, 1'b0, 32'h00000001, 32'h00000080}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sck = 1'b0; fs = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic send_bit(logic b, logic f);
    @(negedge clk);
    sck = 1'b0; sd = b ^ sd_inv; sd_loop = b ^ loop_inv; fs = f;
    tick(3);
    sck = 1'b1;
    tick(4);
  endtask

  task automatic send_frame(int nslots);
    for (int s = 0; s < nslots; s++)
      for (int i = 0; i < 32; i++)
        send_bit(frame_w[s][31-i], (s == 0) && (i == 0));
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 valid after reset", 32'(out_valid), 32'h0);
    chk("R1 overrun after reset", 32'(overrun), 32'h0);

    for (int v = 0; v < 14; v++) begin
      string r;
      r = (v < 1) ? "R2" : (v < 5) ? "R3" : (v < 12) ? "R4" : "R5";
      {cfg_size, cfg_ext, cfg_lsb_first, cfg_slot_left, cfg_word_left} = VEC[v][71:64];
      frame_w[0] = VEC[v][63:32];
      cap_n = 0;
      send_frame(1);
      chk({r, " word count"}, 32'(cap_n), 32'd1);
      chk({r, " data"}, cap_d[0], VEC[v][31:0]);
      chk({r, " slot"}, 32'(cap_s[0]), 32'd0);
    end
    cfg_size = 3'd0; cfg_ext = 2'd0; cfg_lsb_first = 1'b0;
    cfg_slot_left = 1'b0; cfg_word_left = 1'b0;

    // R8: four slots, slot 1 suppressed, trailing bits ignored
    cfg_slots = 3'd3; cfg_slot_dis = 8'b0000_0010;
    frame_w[0] = 32'h11111111; frame_w[1] = 32'h22222222;
    frame_w[2] = 32'h33333333; frame_w[3] = 32'h44444444;
    cap_n = 0;
    send_frame(4);
    for (int i = 0; i < 64; i++) send_bit(i[0], 1'b0);
    tick(4);
    chk("R8 word count", 32'(cap_n), 32'd3);
    chk("R8 data 0", cap_d[0], 32'h11111111);
    chk("R2 slot 0", 32'(cap_s[0]), 32'd0);
    chk("R8 data 2", cap_d[1], 32'h33333333);
    chk("R8 slot 2", 32'(cap_s[1]), 32'd2);
    chk("R8 data 3", cap_d[2], 32'h44444444);
    chk("R2 slot 3", 32'(cap_s[2]), 32'd3);
    cfg_slot_dis = 8'h00;

    // R6: packed stereo
    cfg_slots = 3'd1; cfg_size = 3'd5; cfg_ext = 2'd1;
    frame_w[0] = 32'h1234AAAA; frame_w[1] = 32'h5678BBBB;
    cap_n = 0;
    send_frame(2);
    chk("R6 16 packed count", 32'(cap_n), 32'd1);
    chk("R6 16 packed data", cap_d[0], 32'hBBBBAAAA);
    chk("R6 16 packed slot", 32'(cap_s[0]), 32'd1);
    cfg_size = 3'd7;
    frame_w[0] = 32'h99999911; frame_w[1] = 32'h88888822;
    cap_n = 0;
    send_frame(2);
    chk("R6 8 packed count", 32'(cap_n), 32'd1);
    chk("R6 8 packed data", cap_d[0], 32'h00002211);
    cfg_size = 3'd0; cfg_ext = 2'd0;

    // R7: mono duplication
    cfg_mono = 1'b1;
    frame_w[0] = 32'h11111111; frame_w[1] = 32'h22222222;
    cap_n = 0;
    send_frame(2);
    chk("R7 count", 32'(cap_n), 32'd2);
    chk("R7 left", cap_d[0], 32'h11111111);
    chk("R7 right", cap_d[1], 32'h11111111);
    chk("R7 right slot", 32'(cap_s[1]), 32'd1);
    cfg_mono = 1'b0;

    // R9: loopback source
    cfg_slots = 3'd0; cfg_loop = 1'b1; sd_inv = 1'b1; loop_inv = 1'b0;
    frame_w[0] = 32'hC3C3A5A5;
    cap_n = 0;
    send_frame(1);
    chk("R9 loop data", cap_d[0], 32'hC3C3A5A5);
    cfg_loop = 1'b0; sd_inv = 1'b0; loop_inv = 1'b1;

    // R11: reserved modes
    cfg_mode = 2'd1;
    cap_n = 0;
    send_frame(1);
    cfg_mode = 2'd3;
    send_frame(1);
    chk("R11 reserved count", 32'(cap_n), 32'd0);
    chk("R11 reserved valid", 32'(out_valid), 32'd0);

    // R10: dual-edge capture
    cfg_mode = 2'd2;
    do_reset();
    cap_n = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      sd = 32'hC0FFEE11 >> (31 - i);
      tick(2);
      sck = ~sck;
      tick(2);
    end
    tick(4);
    chk("R10 count", 32'(cap_n), 32'd1);
    chk("R10 data", cap_d[0], 32'hC0FFEE11);
    chk("R10 slot", 32'(cap_s[0]), 32'd0);
    cfg_mode = 2'd0;

    // R12: hold and overrun
    do_reset();
    out_ready = 1'b0; cfg_slots = 3'd1;
    frame_w[0] = 32'h00000001; frame_w[1] = 32'h00000002;
    send_frame(2);
    chk("R12 held valid", 32'(out_valid), 32'd1);
    chk("R12 held data", out_data, 32'h00000001);
    chk("R12 held slot", 32'(out_slot), 32'd0);
    chk("R12 overrun set", 32'(overrun), 32'd1);
    out_ready = 1'b1;
    tick(2);
    chk("R12 drained", 32'(out_valid), 32'd0);
    chk("R12 overrun sticky", 32'(overrun), 32'd1);

    summary();
    $finish;
  end

endmodule